// File: doc/BRIEF.md
# Dual Phase-Frequency Detector with Lock Flags and Monitor Selector

This block sits between the reference dividers and feedback dividers of two synthesizer channels, A and B, and the charge pumps that steer their oscillators. For each channel it pairs a reference strobe with a feedback strobe, both one clock cycle wide. It then issues a three-state pump command for as many cycles as the two strobes lie apart. The command is drive-high, drive-low or released. The sense of the command can be inverted, and the pump can be forced to high impedance. A power-save bit parks the channel and discards any comparison in flight.

Each channel also counts completed comparisons whose error fits a small window, and raises a lock flag once enough of them arrive back to back. One monitor output is shared by both channels. Two select fields choose what it carries: a lock indication, one of the raw strobes, an open-drain fastlock pull-down tied to channel A's current-boost bit, or a counter-clear request to the dividers.

Top module: `dual_pfd_mon`

## Requirements
- R1: With the polarity bit at 1, a reference strobe that arrives k cycles before the feedback strobe makes that channel's pump command read 01 (drive high) for exactly k cycles, starting in the cycle after the reference strobe. A feedback strobe that leads makes it read 10 (drive low) in the same way. Channel A's command is cp_o[1:0] and channel B's is cp_o[3:2].
- R2: With the polarity bit at 0, the drive-high and drive-low responses of R1 are swapped.
- R3: Strobes that arrive in the same cycle leave the command at 00 (released). A one-cycle separation produces a single one-cycle drive pulse, so there is no dead zone.
- R4: A second strobe from the leading side while a comparison is pending keeps the drive active until the lagging strobe arrives. The command never shows 11.
- R5: The high-impedance bit forces the command to 00 in the same cycle, whatever the phase. A comparison that is pending continues to drive once the bit is cleared.
- R6: The power-save bit forces the command to 00, discards any pending comparison and clears that channel's lock flag.
- R7: The lock flag rises in the cycle after the LOCK_CNT-th consecutive completed comparison whose strobe separation is at most LOCK_WIN cycles.
- R8: The lock flag falls in the cycle after the first completed comparison whose separation exceeds LOCK_WIN.
- R9: With csel_i = 00, the monitor behaves as follows. lsel_i = 00 releases it (mon_oe_o = 0). lsel_i = 01 drives channel A's lock flag. lsel_i = 10 drives channel B's lock flag. lsel_i = 11 drives the AND of both flags.
- R10: With exactly one csel_i bit set (bit 0 for A, bit 1 for B), the monitor drives that channel's feedback strobe when lsel_i[1] = 1 and its reference strobe otherwise.
- R11: With csel_i = 11 and lsel_i = 00 (fastlock), the monitor value is 0 and mon_oe_o follows boost_a_i.
- R12: With csel_i = 11 and lsel_i not 00, cnt_clr_o equals lsel_i (bit 0 for A, bit 1 for B) and the monitor is released. In every other setting cnt_clr_o is 00.
- R13: During reset, every pump command reads 00 and both lock flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_stb_i | input | 2 | Reference strobes, bit 0 for A, bit 1 for B |
| fb_stb_i | input | 2 | Feedback strobes, one per channel |
| pol_i | input | 2 | Polarity bit per channel (1 means a leading reference drives high) |
| hiz_i | input | 2 | Force the pump output to high impedance, per channel |
| boost_a_i | input | 1 | Channel A current-boost bit, used by fastlock |
| sleep_i | input | 2 | Power-save bit per channel |
| lsel_i | input | 2 | Monitor select, lock field |
| csel_i | input | 2 | Monitor select, clock field |
| cp_o | output | 4 | Pump commands, 2 bits per channel: 00 released, 01 high, 10 low |
| lock_o | output | 2 | Lock flags per channel |
| mon_o | output | 1 | Monitor output value |
| mon_oe_o | output | 1 | Monitor output enable (0 means released) |
| cnt_clr_o | output | 2 | Counter-clear requests per channel |

## Verification
The hardest states to reach are the lock threshold and its loss. The flag moves only after a run of completed pairs whose separations have exactly the right size, and it depends on what both channels did in the past. The stimulus produces eight one-cycle-error pairs on channel A alongside eight zero-error pairs on channel B, then one three-cycle pair on A alone. That leaves the channels in opposite lock states before the monitor sweep, so the AND setting and the single-channel settings give different answers. Two further sequences hold a comparison pending: one while high impedance is forced, and one into power-save. They show whether the pending state survives or is dropped.

// File: rtl/dpfd_pkg.sv
`timescale 1ns/1ps
package dpfd_pkg;
   // pump command encoding shared by the detector and the top
   typedef enum logic [1:0] {
      CP_Z  = 2'b00,
      CP_HI = 2'b01,
      CP_LO = 2'b10
   } cp_e;
endpackage

// File: rtl/dpfd_core.sv
`timescale 1ns/1ps
module dpfd_core
   import dpfd_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_stb_i,
   input  logic fb_stb_i,
   input  logic pol_i,
   input  logic hiz_i,
   input  logic sleep_i,
   output cp_e  cp_o,
   output logic busy_o,
   output logic done_o
);
   logic up_q, dn_q;
   logic ref_seen, fb_seen;

   assign ref_seen = up_q | ref_stb_i;
   assign fb_seen  = dn_q | fb_stb_i;
   assign done_o   = ~sleep_i & ref_seen & fb_seen;
   assign busy_o   = up_q | dn_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (sleep_i) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= ref_seen & ~fb_seen;
         dn_q <= fb_seen & ~ref_seen;
      end
   end

   always_comb begin
      cp_o = CP_Z;
      if (!(hiz_i || sleep_i)) begin
         if (up_q)      cp_o = pol_i ? CP_HI : CP_LO;
         else if (dn_q) cp_o = pol_i ? CP_LO : CP_HI;
      end
   end

   // R4
   no_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(up_q && dn_q));
   // R1
   up_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(up_q) |-> $past(ref_stb_i));
   // R6
   sleep_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(sleep_i) |-> !(up_q || dn_q));
endmodule

// File: rtl/dpfd_lock.sv
`timescale 1ns/1ps
module dpfd_lock #(
   parameter int LOCK_CNT = 8,
   parameter int LOCK_WIN = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_i,
   input  logic busy_i,
   input  logic done_i,
   output logic locked_o
);
   localparam int CW = $clog2(LOCK_CNT + 1);

   logic          good;
   logic [CW-1:0] cnt_q;

   generate
      if (LOCK_WIN == 0) begin : g_exact
         assign good = !busy_i;
      end else begin : g_win
         localparam int EW = $clog2(LOCK_WIN + 2);
         logic [EW-1:0] err_q;
         logic [EW:0]   err_now;
         assign err_now = busy_i ? ({1'b0, err_q} + (EW+1)'(1)) : '0;
         assign good    = err_now <= (EW+1)'(LOCK_WIN);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                err_q <= '0;
            else if (sleep_i || done_i) err_q <= '0;
            else if (busy_i && err_q != EW'(LOCK_WIN + 1))
               err_q <= err_q + EW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (sleep_i) cnt_q <= '0;
      else if (done_i) begin
         if (!good)                        cnt_q <= '0;
         else if (cnt_q != CW'(LOCK_CNT))  cnt_q <= cnt_q + CW'(1);
      end
   end

   assign locked_o = cnt_q == CW'(LOCK_CNT);

   // R7
   lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_o) |-> $past(done_i && good));
   // R8
   lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && !good && !sleep_i) |=> !locked_o);
endmodule

// File: rtl/dpfd_mon.sv
`timescale 1ns/1ps
module dpfd_mon (
   input  logic [1:0] lsel_i,
   input  logic [1:0] csel_i,
   input  logic [1:0] lock_i,
   input  logic [1:0] ref_stb_i,
   input  logic [1:0] fb_stb_i,
   input  logic       boost_a_i,
   output logic       mon_o,
   output logic       oe_o,
   output logic [1:0] clr_o
);
   logic ch;

   assign ch = csel_i[1];

   always_comb begin
      mon_o = 1'b0;
      oe_o  = 1'b0;
      clr_o = 2'b00;
      unique case (csel_i)
         2'b00: begin
            oe_o = |lsel_i;
            unique case (lsel_i)
               2'b01:   mon_o = lock_i[0];
               2'b10:   mon_o = lock_i[1];
               2'b11:   mon_o = &lock_i;
               default: mon_o = 1'b0;
            endcase
         end
         2'b01, 2'b10: begin
            oe_o  = 1'b1;
            mon_o = lsel_i[1] ? fb_stb_i[ch] : ref_stb_i[ch];
         end
         default: begin
            if (lsel_i == 2'b00) oe_o  = boost_a_i;
            else                 clr_o = lsel_i;
         end
      endcase
   end
endmodule

// File: rtl/dual_pfd_mon.sv
`timescale 1ns/1ps
module dual_pfd_mon #(
   parameter int LOCK_CNT = 8,
   parameter int LOCK_WIN = 1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] ref_stb_i,
   input  logic [1:0] fb_stb_i,
   input  logic [1:0] pol_i,
   input  logic [1:0] hiz_i,
   input  logic       boost_a_i,
   input  logic [1:0] sleep_i,
   input  logic [1:0] lsel_i,
   input  logic [1:0] csel_i,
   output logic [3:0] cp_o,
   output logic [1:0] lock_o,
   output logic       mon_o,
   output logic       mon_oe_o,
   output logic [1:0] cnt_clr_o
);
   import dpfd_pkg::*;
   localparam int NCH = 2;

   generate
      if (LOCK_CNT < 1 || LOCK_WIN < 0) begin : g_bad_cfg
         $error("dual_pfd_mon: LOCK_CNT must be >= 1 and LOCK_WIN >= 0");
      end
   endgenerate

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         cp_e  cp_w;
         logic busy_w, done_w;
         dpfd_core u_core (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ref_stb_i (ref_stb_i[g]),
            .fb_stb_i  (fb_stb_i[g]),
            .pol_i     (pol_i[g]),
            .hiz_i     (hiz_i[g]),
            .sleep_i   (sleep_i[g]),
            .cp_o      (cp_w),
            .busy_o    (busy_w),
            .done_o    (done_w)
         );
         dpfd_lock #(.LOCK_CNT(LOCK_CNT), .LOCK_WIN(LOCK_WIN)) u_lock (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sleep_i  (sleep_i[g]),
            .busy_i   (busy_w),
            .done_i   (done_w),
            .locked_o (lock_o[g])
         );
         assign cp_o[2*g +: 2] = cp_w;
      end
   endgenerate

   dpfd_mon u_mon (
      .lsel_i    (lsel_i),
      .csel_i    (csel_i),
      .lock_i    (lock_o),
      .ref_stb_i (ref_stb_i),
      .fb_stb_i  (fb_stb_i),
      .boost_a_i (boost_a_i),
      .mon_o     (mon_o),
      .oe_o      (mon_oe_o),
      .clr_o     (cnt_clr_o)
   );

   // R11
   fast_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csel_i == 2'b11 && lsel_i == 2'b00 && mon_oe_o) |-> !mon_o);
   // R12
   clr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|cnt_clr_o) |-> !mon_oe_o);
endmodule

// File: tb/dual_pfd_mon_tb_top.sv
`timescale 1ns/1ps
module dual_pfd_mon_tb_top;
   localparam int CNT = 8;
   localparam int WIN = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_s = '0, fb_s = '0, pol = 2'b11, hiz = '0, sleep = '0;
   logic [1:0] lsel = '0, csel = '0;
   logic       boost = 1'b0;
   logic [3:0] cp;
   logic [1:0] lock, clr;
   logic       mon, mon_oe;

   int    checks = 0, errors = 0;
   bit    chk_en = 0;
   bit    done_run = 0;
   string cur_req = "R13";

   int lead [2];
   int held [2];
   int good [2];

   always #5 clk = ~clk;

   dual_pfd_mon #(.LOCK_CNT(CNT), .LOCK_WIN(WIN)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ref_stb_i(ref_s), .fb_stb_i(fb_s),
      .pol_i(pol), .hiz_i(hiz), .boost_a_i(boost), .sleep_i(sleep),
      .lsel_i(lsel), .csel_i(csel), .cp_o(cp), .lock_o(lock),
      .mon_o(mon), .mon_oe_o(mon_oe), .cnt_clr_o(clr)
   );

   task automatic check(input string req, input bit ok, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference: pending leader, cycles held, good-pair run
   always @(posedge clk) begin
      bit rs, fs;
      int e;
      for (int c = 0; c < 2; c++) begin
         if (!rst_n || sleep[c]) begin
            lead[c] = 0; held[c] = 0; good[c] = 0;
         end else begin
            rs = ref_s[c] || lead[c] == 1;
            fs = fb_s[c]  || lead[c] == 2;
            if (rs && fs) begin
               e = (lead[c] != 0) ? held[c] + 1 : 0;
               lead[c] = 0; held[c] = 0;
               if (e <= WIN) good[c] = (good[c] < CNT) ? good[c] + 1 : good[c];
               else          good[c] = 0;
            end else if (rs) begin
               if (lead[c] == 1) held[c]++;
               lead[c] = 1;
            end else if (fs) begin
               if (lead[c] == 2) held[c]++;
               lead[c] = 2;
            end
         end
      end
   end

   function automatic int exp_cp(int c);
      if (sleep[c] || hiz[c]) return 0;
      if (lead[c] == 1) return pol[c] ? 1 : 2;
      if (lead[c] == 2) return pol[c] ? 2 : 1;
      return 0;
   endfunction

   function automatic int exp_lock(int c);
      return (good[c] == CNT) ? 1 : 0;
   endfunction

   always @(negedge clk) begin
      int em, eo, ec;
      if (chk_en && !done_run) begin
         for (int c = 0; c < 2; c++) begin
            check(cur_req, cp[2*c +: 2] == 2'(exp_cp(c)), $sformatf("cp ch%0d", c),
                  int'(cp[2*c +: 2]), exp_cp(c));
            check(cur_req, lock[c] == 1'(exp_lock(c)), $sformatf("lock ch%0d", c),
                  int'(lock[c]), exp_lock(c));
         end
         em = 0; eo = 0; ec = 0;
         case (csel)
            2'b00: begin
               eo = (lsel != 0) ? 1 : 0;
               if (lsel == 2'b01) em = exp_lock(0);
               if (lsel == 2'b10) em = exp_lock(1);
               if (lsel == 2'b11) em = exp_lock(0) & exp_lock(1);
            end
            2'b01: begin eo = 1; em = lsel[1] ? int'(fb_s[0]) : int'(ref_s[0]); end
            2'b10: begin eo = 1; em = lsel[1] ? int'(fb_s[1]) : int'(ref_s[1]); end
            default: begin
               if (lsel == 0) eo = int'(boost);
               else           ec = int'(lsel);
            end
         endcase
         check(cur_req, mon == 1'(em), "mon", int'(mon), em);
         check(cur_req, mon_oe == 1'(eo), "mon_oe", int'(mon_oe), eo);
         check(cur_req, clr == 2'(ec), "cnt_clr", int'(clr), ec);
      end
   end

   task automatic step(input logic [1:0] r, input logic [1:0] f);
      @(posedge clk); #2;
      ref_s = r; fb_s = f;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(2'b00, 2'b00);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      chk_en = 1;
      @(negedge clk);
      check("R13", cp == 4'b0000, "reset cp", int'(cp), 0);
      check("R13", lock == 2'b00, "reset lock", int'(lock), 0);
      @(posedge clk); #2 rst_n = 1'b1;

      cur_req = "R1";
      step(2'b01, 2'b00); idle(2); step(2'b00, 2'b01); idle(3);
      step(2'b00, 2'b01); idle(1); step(2'b01, 2'b00); idle(3);

      cur_req = "R2";
      pol = 2'b00;
      step(2'b01, 2'b00); idle(2); step(2'b00, 2'b01); idle(2);
      step(2'b00, 2'b10); idle(1); step(2'b10, 2'b00); idle(2);
      pol = 2'b11;

      cur_req = "R3";
      step(2'b11, 2'b11); idle(2);
      step(2'b01, 2'b00); step(2'b00, 2'b01); idle(2);

      cur_req = "R4";
      step(2'b01, 2'b00); step(2'b01, 2'b00); idle(1); step(2'b00, 2'b01); idle(2);

      cur_req = "R5";
      step(2'b01, 2'b00); hiz = 2'b01; idle(2); hiz = 2'b00; idle(1);
      step(2'b00, 2'b01); idle(2);

      cur_req = "R6";
      step(2'b01, 2'b00); sleep = 2'b01; idle(2); sleep = 2'b00;
      step(2'b00, 2'b01); idle(2); step(2'b01, 2'b00); idle(2);

      cur_req = "R7";
      for (int i = 0; i < CNT; i++) begin
         step(2'b11, 2'b10); step(2'b00, 2'b01); step(2'b00, 2'b00);
         @(negedge clk);
         if (i == CNT - 2)
            check("R7", lock[0] == 1'b0, "lock A before threshold", int'(lock[0]), 0);
      end
      check("R7", lock == 2'b11, "lock after threshold", int'(lock), 3);

      cur_req = "R8";
      step(2'b01, 2'b00); idle(2); step(2'b00, 2'b01); idle(1);
      @(negedge clk);
      check("R8", lock == 2'b10, "lock after wide error", int'(lock), 2);

      for (int cs = 0; cs < 4; cs++)
         for (int ls = 0; ls < 4; ls++)
            for (int b = 0; b < 2; b++) begin
               if (cs == 0)                cur_req = "R9";
               else if (cs != 3)           cur_req = "R10";
               else if (ls == 0)           cur_req = "R11";
               else                        cur_req = "R12";
               @(posedge clk); #2;
               csel = 2'(cs); lsel = 2'(ls); boost = 1'(b);
               step(2'b11, 2'b00); step(2'b00, 2'b11); idle(1);
            end

      idle(2);
      done_run = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_run) begin
         done_run = 1;
         checks++; errors++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule